// File: doc/BRIEF.md
# Step-Down Regulator Startup and Mode Sequencer

This block is the digital sequencer for a synchronous step-down regulator. It takes comparator flags that already quantise a three-level enable/mode pin, the ready flags of the internal reference and of the supply, digitised threshold-strap codes, an output-in-window flag and a free-running timebase tick. From these it drives the operating mode, a soft-start active flag, the latched threshold selections, a fault-clear pulse and a power-good output.

The sequence runs as follows. Leaving the disable level emits a one-cycle pulse that clears latched protection faults. The sequencer then waits for the reference and then the supply. Next it spends a timed window sampling the overcurrent strap, followed by a timed window sampling the transient-enhancement strap. A timed soft-start follows, with forced-PWM imposed. In the run phase the mode follows the debounced level input, and power-good rises and falls with separate delays. Every duration is a parameter counted in timebase ticks. Dropping the enable level returns the block to its off state from any phase.

Top module: `buck_seq_top`

## Requirements
- R1: After reset, `mode_o` is 0 (off), `ss_active`, `pgood` and `flt_clr` are 0, and both selections are 0.
- R2: When `lvl_en` is low, the sequencer reaches its off state at the next clock edge from any phase. Within two clock cycles, `mode_o` is 0 and `ss_active` and `pgood` are 0.
- R3: A rise of `lvl_en` seen while off produces exactly one `flt_clr` pulse, one clock wide.
- R4: Progress past the wait phase needs `ref_ok`. While `ref_ok` is low, `vcc_ok` and `tick` have no effect. Once both are high, the first configuration window starts at the next edge.
- R5: The overcurrent window lasts `OCP_TICKS` ticks. `ocp_cmp` is sampled on its last tick only. The thermometer code decodes as 00 to 0 (default), 01 to 1 (adjustable) and 1x to 2 (disabled) on `ocp_sel`.
- R6: The transient-enhancement window lasts `TRE_TICKS` ticks and follows the overcurrent window. `tre_cmp` is sampled on its last tick. It decodes as 00 to 0 (default code), 01 to 1 (alternate code) and 1x to 2 (feature off) on `tre_sel`.
- R7: Soft-start lasts `SS_TICKS` ticks with `ss_active` high. Throughout it, `mode_o` is 1 (forced PWM) whatever `lvl_skip` is.
- R8: In run, `mode_o` is 2 (skip) when the debounced `lvl_skip` is 1, and 1 (forced PWM) when it is 0. The level present when the block leaves off applies with no delay.
- R9: A change of `lvl_skip` takes effect only after it has held for `DEB_TICKS` consecutive ticks. A shorter excursion leaves `mode_o` unchanged.
- R10: In run, `pgood` rises after `fb_ok` has been high for `PG_ON_TICKS` consecutive ticks.
- R11: `pgood` falls after `fb_ok` has been low for `PG_OFF_TICKS` consecutive ticks. A shorter dip leaves it high.
- R12: Loss of `ref_ok` or `vcc_ok` after the wait phase returns the sequencer to waiting. `mode_o`, `ss_active` and `pgood` go to 0, and both configuration windows run again.
- R13: `ocp_sel` and `tre_sel` hold their values in run, whatever `ocp_cmp` and `tre_cmp` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe |
| lvl_en | input | 1 | Level above the disable threshold |
| lvl_skip | input | 1 | Level above the skip-mode threshold |
| ref_ok | input | 1 | Reference in regulation |
| vcc_ok | input | 1 | Supply above its lockout threshold |
| ocp_cmp | input | 2 | Overcurrent strap thermometer code |
| tre_cmp | input | 2 | Transient-enhancement strap thermometer code |
| fb_ok | input | 1 | Feedback inside the power-good window |
| mode_o | output | 2 | 0 off, 1 forced PWM, 2 skip |
| ss_active | output | 1 | Soft-start in progress |
| ocp_sel | output | 2 | Latched overcurrent selection |
| tre_sel | output | 2 | Latched transient-enhancement selection |
| pgood | output | 1 | Power good |
| flt_clr | output | 1 | Fault-clear pulse on leaving disable |

## Verification
A wrong phase or a miscounted window shows up as `ss_active` rising one or more ticks early or late relative to the ticks the bench issues. A sampling error shows up as a selection code that differs from the strap value present on the last tick of its window, visible in the cycle after that tick. Debounce and power-good filter faults shift the first tick at which `mode_o` or `pgood` changes. The sweep drives every strap code pair and alternates the skip level. Because of that, a swapped decode or a mode ignored during soft-start appears within one startup.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_REF    = 3'd1,
    ST_CFG_OC = 3'd2,
    ST_CFG_TR = 3'd3,
    ST_SS     = 3'd4,
    ST_RUN    = 3'd5
  } seq_st_t;

  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_FPWM = 2'd1,
    MD_SKIP = 2'd2
  } mode_t;

  // Thermometer strap code: 00 -> 0, 01 -> 1, 1x -> 2
  function automatic logic [1:0] therm_decode(input logic [1:0] t);
    if (t[1])      return 2'd2;
    else if (t[0]) return 2'd1;
    else           return 2'd0;
  endfunction

endpackage

// File: rtl/seq_mode_deb.sv
module seq_mode_deb #(
  parameter int DEB_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic tick,
  input  logic raw,
  output logic deb
);
  localparam int DW = (DEB_TICKS < 2) ? 1 : $clog2(DEB_TICKS);
  localparam logic [DW-1:0] LIM = DW'(DEB_TICKS - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      deb <= 1'b0;
      cnt <= '0;
    end else if (hold) begin
      deb <= raw;
      cnt <= '0;
    end else if (raw == deb) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LIM) begin
        deb <= raw;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_cfg_latch.sv
module seq_cfg_latch
  import buck_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sample,
  input  logic [1:0] cmp,
  output logic [1:0] sel
);
  always_ff @(posedge clk) begin
    if (rst)         sel <= 2'd0;
    else if (sample) sel <= therm_decode(cmp);
  end
endmodule

// File: rtl/seq_pg_filter.sv
module seq_pg_filter #(
  parameter int ON_TICKS  = 10,
  parameter int OFF_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic fb_ok,
  output logic pg
);
  localparam int MX = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int PW = (MX < 2) ? 1 : $clog2(MX);
  localparam logic [PW-1:0] ON_LIM  = PW'(ON_TICKS - 1);
  localparam logic [PW-1:0] OFF_LIM = PW'(OFF_TICKS - 1);

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;

  assign lim = pg ? OFF_LIM : ON_LIM;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pg  <= 1'b0;
      cnt <= '0;
    end else if (fb_ok == pg) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == lim) begin
        pg  <= ~pg;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buck_seq_top.sv
module buck_seq_top
  import buck_seq_pkg::*;
#(
  parameter int OCP_TICKS    = 130,
  parameter int TRE_TICKS    = 40,
  parameter int SS_TICKS     = 110,
  parameter int DEB_TICKS    = 8,
  parameter int PG_ON_TICKS  = 10,
  parameter int PG_OFF_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       lvl_en,
  input  logic       lvl_skip,
  input  logic       ref_ok,
  input  logic       vcc_ok,
  input  logic [1:0] ocp_cmp,
  input  logic [1:0] tre_cmp,
  input  logic       fb_ok,
  output logic [1:0] mode_o,
  output logic       ss_active,
  output logic [1:0] ocp_sel,
  output logic [1:0] tre_sel,
  output logic       pgood,
  output logic       flt_clr
);
  localparam int MAX_AB = (OCP_TICKS > TRE_TICKS) ? OCP_TICKS : TRE_TICKS;
  localparam int MAXT   = (MAX_AB > SS_TICKS) ? MAX_AB : SS_TICKS;
  localparam int CW     = (MAXT < 2) ? 1 : $clog2(MAXT);
  localparam logic [CW-1:0] OC_LIM = CW'(OCP_TICKS - 1);
  localparam logic [CW-1:0] TR_LIM = CW'(TRE_TICKS - 1);
  localparam logic [CW-1:0] SS_LIM = CW'(SS_TICKS - 1);

  seq_st_t       st, st_n;
  logic [CW-1:0] cnt, lim;
  logic          timed, last, oc_smp, tr_smp, deb_skip, pg_en, supply_ok;
  mode_t         mode_n;

  assign supply_ok = ref_ok && vcc_ok;

  always_comb begin
    timed = 1'b1;
    case (st)
      ST_CFG_OC: lim = OC_LIM;
      ST_CFG_TR: lim = TR_LIM;
      ST_SS:     lim = SS_LIM;
      default: begin
        lim   = '0;
        timed = 1'b0;
      end
    endcase
  end

  assign last = timed && tick && (cnt == lim);

  always_comb begin
    st_n   = st;
    oc_smp = 1'b0;
    tr_smp = 1'b0;
    if (!lvl_en) begin
      st_n = ST_OFF;
    end else begin
      case (st)
        ST_OFF: st_n = ST_REF;
        ST_REF: if (supply_ok) st_n = ST_CFG_OC;
        default: begin
          if (!supply_ok) begin
            st_n = ST_REF;
          end else begin
            case (st)
              ST_CFG_OC: if (last) begin
                oc_smp = 1'b1;
                st_n   = ST_CFG_TR;
              end
              ST_CFG_TR: if (last) begin
                tr_smp = 1'b1;
                st_n   = ST_SS;
              end
              ST_SS: if (last) st_n = ST_RUN;
              default: st_n = st;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    case (st_n)
      ST_SS:   mode_n = MD_FPWM;
      ST_RUN:  mode_n = deb_skip ? MD_SKIP : MD_FPWM;
      default: mode_n = MD_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_OFF;
      cnt       <= '0;
      mode_o    <= MD_OFF;
      ss_active <= 1'b0;
      flt_clr   <= 1'b0;
    end else begin
      st        <= st_n;
      mode_o    <= mode_n;
      ss_active <= (st_n == ST_SS);
      flt_clr   <= (st == ST_OFF) && (st_n == ST_REF);
      if (st_n != st)        cnt <= '0;
      else if (timed && tick) cnt <= cnt + 1'b1;
    end
  end

  seq_mode_deb #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst(rst), .hold(st == ST_OFF), .tick(tick),
    .raw(lvl_skip), .deb(deb_skip)
  );

  seq_cfg_latch u_oc (
    .clk(clk), .rst(rst), .sample(oc_smp), .cmp(ocp_cmp), .sel(ocp_sel)
  );

  seq_cfg_latch u_tr (
    .clk(clk), .rst(rst), .sample(tr_smp), .cmp(tre_cmp), .sel(tre_sel)
  );

  assign pg_en = (st == ST_RUN) && (st_n == ST_RUN);

  seq_pg_filter #(.ON_TICKS(PG_ON_TICKS), .OFF_TICKS(PG_OFF_TICKS)) u_pg (
    .clk(clk), .rst(rst), .en(pg_en), .tick(tick), .fb_ok(fb_ok), .pg(pgood)
  );

endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk
  import buck_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       lvl_en,
  input logic       ref_ok,
  input logic [2:0] st,
  input logic [1:0] mode_o,
  input logic       ss_active,
  input logic       pgood,
  input logic       flt_clr,
  input logic [1:0] ocp_sel,
  input logic [1:0] tre_sel
);
  a_r2_off_next: assert property (@(posedge clk) disable iff (rst)
    !lvl_en |=> (st == ST_OFF));

  a_r2_off_mode: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF) |=> (mode_o == MD_OFF || lvl_en));

  a_r3_clr_single: assert property (@(posedge clk) disable iff (rst)
    flt_clr |=> !flt_clr);

  a_r3_clr_in_wait: assert property (@(posedge clk) disable iff (rst)
    flt_clr |-> (st == ST_REF || st == ST_OFF));

  a_r4_ref_gate: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REF && !ref_ok) |=> (st == ST_REF || st == ST_OFF));

  a_r7_ss_fpwm: assert property (@(posedge clk) disable iff (rst)
    ss_active |-> (mode_o == MD_FPWM));

  a_r10_pg_in_run: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (!ss_active && mode_o != MD_OFF));

  a_r13_sel_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |=> (st != ST_RUN) || ($stable(ocp_sel) && $stable(tre_sel)));
endmodule

bind buck_seq_top buck_seq_chk u_chk (
  .clk(clk), .rst(rst), .lvl_en(lvl_en), .ref_ok(ref_ok), .st(st),
  .mode_o(mode_o), .ss_active(ss_active), .pgood(pgood), .flt_clr(flt_clr),
  .ocp_sel(ocp_sel), .tre_sel(tre_sel)
);

// File: tb/sim_buck_seq_top.sv
module sim_buck_seq_top;
  localparam int CLK_PER = 10;
  localparam int OCT = 5, TRT = 3, SST = 7, DBT = 3, PGN = 4, PGF = 2;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, lvl_en = 1'b0, lvl_skip = 1'b0;
  logic ref_ok = 1'b0, vcc_ok = 1'b0, fb_ok = 1'b0;
  logic [1:0] ocp_cmp = 2'd0, tre_cmp = 2'd0;
  logic [1:0] mode_o, ocp_sel, tre_sel;
  logic ss_active, pgood, flt_clr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  buck_seq_top #(.OCP_TICKS(OCT), .TRE_TICKS(TRT), .SS_TICKS(SST),
    .DEB_TICKS(DBT), .PG_ON_TICKS(PGN), .PG_OFF_TICKS(PGF)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .lvl_en(lvl_en), .lvl_skip(lvl_skip),
    .ref_ok(ref_ok), .vcc_ok(vcc_ok), .ocp_cmp(ocp_cmp), .tre_cmp(tre_cmp),
    .fb_ok(fb_ok), .mode_o(mode_o), .ss_active(ss_active), .ocp_sel(ocp_sel),
    .tre_sel(tre_sel), .pgood(pgood), .flt_clr(flt_clr));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      wclk(2);
    end
  endtask

  function automatic int dec(input int c);
    return (c >= 2) ? 2 : c;
  endfunction

  // Counts ticks until ss_active rises
  task automatic ticks_to_ss(output int n);
    n = 0;
    for (int i = 0; i < 40 && !ss_active; i++) begin
      tk(1);
      n++;
    end
  endtask

  initial begin
    int n, m, pc;
    wclk(3);
    rst = 1'b0;
    wclk(1);
    chk("R1 mode", mode_o, 0);
    chk("R1 ss", ss_active, 0);
    chk("R1 pgood", pgood, 0);
    chk("R1 flt_clr", flt_clr, 0);
    chk("R1 sel", {ocp_sel, tre_sel}, 0);

    for (int oc = 0; oc < 4; oc++) begin
      for (int tr = 0; tr < 4; tr++) begin
        lvl_en = 1'b0; fb_ok = 1'b0; ref_ok = 1'b0; vcc_ok = 1'b1;
        wclk(3);
        chk("R2 mode off", mode_o, 0);
        chk("R2 pgood off", pgood, 0);
        lvl_skip = 1'((oc + tr) % 2);
        ocp_cmp = 2'(~oc); tre_cmp = 2'(~tr);
        lvl_en = 1'b1;
        pc = 0;
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          if (flt_clr) pc++;
        end
        chk("R3 clr pulses", pc, 1);
        tk(3);
        chk("R4 no ss without ref", ss_active, 0);
        ref_ok = 1'b1;
        wclk(2);
        tk(OCT - 1);
        ocp_cmp = 2'(oc);
        tk(1);
        ocp_cmp = 2'(~oc);
        chk("R5 ocp decode", ocp_sel, dec(oc));
        chk("R5 no ss yet", ss_active, 0);
        tk(TRT - 1);
        chk("R6 window length", ss_active, 0);
        tre_cmp = 2'(tr);
        tk(1);
        tre_cmp = 2'(~tr);
        chk("R6 tre decode", tre_sel, dec(tr));
        chk("R7 ss start", ss_active, 1);
        chk("R7 forced pwm", mode_o, 1);
        tk(SST - 1);
        chk("R7 ss held", ss_active, 1);
        chk("R7 forced pwm end", mode_o, 1);
        tk(1);
        chk("R7 ss end", ss_active, 0);
        chk("R8 run mode", mode_o, lvl_skip ? 2 : 1);
        fb_ok = 1'b1;
        tk(PGN - 1);
        chk("R10 pg early", pgood, 0);
        tk(1);
        chk("R10 pg rise", pgood, 1);
        ocp_cmp = 2'd3; tre_cmp = 2'd1;
        tk(2);
        chk("R13 ocp hold", ocp_sel, dec(oc));
        chk("R13 tre hold", tre_sel, dec(tr));
      end
    end

    // in run now, pgood high
    m = mode_o;
    lvl_skip = ~lvl_skip;
    tk(DBT - 1);
    lvl_skip = ~lvl_skip;
    tk(3);
    chk("R9 glitch ignored", mode_o, m);
    lvl_skip = ~lvl_skip;
    tk(DBT - 1);
    chk("R9 not yet", mode_o, m);
    tk(1);
    chk("R9 changed", mode_o, (m == 2) ? 1 : 2);

    fb_ok = 1'b0;
    tk(PGF - 1);
    fb_ok = 1'b1;
    tk(3);
    chk("R11 dip ignored", pgood, 1);
    fb_ok = 1'b0;
    tk(PGF - 1);
    chk("R11 pg held", pgood, 1);
    tk(1);
    chk("R11 pg fall", pgood, 0);

    fb_ok = 1'b1;
    tk(PGN);
    vcc_ok = 1'b0;
    wclk(3);
    chk("R12 mode", mode_o, 0);
    chk("R12 pgood", pgood, 0);
    chk("R12 ss", ss_active, 0);
    vcc_ok = 1'b1;
    wclk(2);
    ticks_to_ss(n);
    chk("R12 redo config ticks", n, OCT + TRT);

    lvl_en = 1'b0;
    wclk(3);
    chk("R2 off from ss", ss_active, 0);
    chk("R2 mode from ss", mode_o, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule